// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns an unsigned 8-bit binary value into three packed decimal digits. It uses the shift-and-add-3 method and performs one step of the method per clock cycle, so the hardware for a single step is reused. A full unrolled chain of correction stages is not built.

A caller pulses `start` for one cycle with the operand on `bin_in`. The block raises `busy` for eight cycles. It then pulses `done` for one cycle, and in that same cycle the new result appears on `bcd_out`. The result stays unchanged until the next conversion finishes. Hundreds sit in bits [11:8], tens in bits [7:4] and units in bits [3:0].

Top module: `bcd_seq_conv`

## Requirements
- R1: While `rst` is high at a rising edge, `busy`, `done` and `bcd_out` are all driven to zero after that edge, whatever `start` does.
- R2: A `start` pulse sampled while the block is idle makes `busy` high from the next cycle onward.
- R3: `busy` stays high for exactly 8 consecutive cycles for each accepted start.
- R4: `done` is high for exactly one cycle. That cycle is the first one after `busy` falls.
- R5: When `done` is high, `bcd_out` holds the input value in decimal: hundreds in bits [11:8], tens in bits [7:4], units in bits [3:0]. This holds for every input from 0 to 255.
- R6: Fixed cases: input 0x63 gives 0x099, 0xFE gives 0x254, and 0xBB gives 0x187.
- R7: A `start` pulse sampled while `busy` is high has no effect. The running conversion keeps its operand and its 8-cycle length.
- R8: `bcd_out` changes only in a cycle where `done` is high. It keeps the previous result while a new conversion runs and after it finishes.
- R9: Every 4-bit digit of `bcd_out` is at most 9 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; operand is taken from `bin_in` in the same cycle |
| bin_in | input | 8 | Unsigned binary operand |
| busy | output | 1 | High while the conversion steps are running |
| done | output | 1 | One-cycle pulse marking a new result |
| bcd_out | output | 12 | Registered packed decimal result |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges have passed. They also assume that `start` is a level sampled at rising edges, with no protocol beyond that: a start that arrives during `busy` may be present and has to be tolerated. The bench changes inputs only on falling edges, so inputs are stable at every rising edge. It raises `start` in the middle of a running conversion, so the ignore path is actually exercised and not just assumed.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

    // Pre-correction applied to one decimal digit between shifts
    function automatic logic [DIGIT_W-1:0] digit_fix(input logic [DIGIT_W-1:0] d);
        return (d > 4'd4) ? d + 4'd3 : d;
    endfunction

endpackage

// File: rtl/bcdc_step.sv
module bcdc_step
    import bcdc_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*DIGIT_W-1:0] acc_in,
    input  logic                      bit_in,
    input  logic                      last,
    output logic [DIGITS*DIGIT_W-1:0] acc_out
);
    localparam int ACC_W = DIGITS * DIGIT_W;

    logic [ACC_W-1:0] shifted;

    assign shifted = {acc_in[ACC_W-2:0], bit_in};

    // Each digit is corrected on its own, except after the final shift
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign acc_out[g*DIGIT_W +: DIGIT_W] =
            last ? shifted[g*DIGIT_W +: DIGIT_W]
                 : digit_fix(shifted[g*DIGIT_W +: DIGIT_W]);
    end

endmodule

// File: rtl/bcdc_ctrl.sv
module bcdc_ctrl
    import bcdc_pkg::*;
#(
    parameter int BIN_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic busy,
    output logic last_step,
    output logic done
);
    localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BIN_W - 1);

    conv_state_e      state;
    logic [CNT_W-1:0] step_cnt;

    assign busy      = (state == ST_RUN);
    assign load      = (state == ST_IDLE) && start;
    assign last_step = busy && (step_cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (last_step) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcd_seq_conv.sv
module bcd_seq_conv
    import bcdc_pkg::*;
#(
    parameter int BIN_W  = 8,
    parameter int DIGITS = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [BIN_W-1:0]          bin_in,
    output logic                      busy,
    output logic                      done,
    output logic [DIGITS*DIGIT_W-1:0] bcd_out
);
    localparam int ACC_W = DIGITS * DIGIT_W;

    logic             load;
    logic             last_step;
    logic [BIN_W-1:0] opnd_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;

    bcdc_ctrl #(.BIN_W(BIN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load      (load),
        .busy      (busy),
        .last_step (last_step),
        .done      (done)
    );

    bcdc_step #(.DIGITS(DIGITS)) u_step (
        .acc_in  (acc_q),
        .bit_in  (opnd_q[BIN_W-1]),
        .last    (last_step),
        .acc_out (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q  <= '0;
            acc_q   <= '0;
            bcd_out <= '0;
        end else begin
            if (load) begin
                opnd_q <= bin_in;
                acc_q  <= '0;
            end else if (busy) begin
                opnd_q <= {opnd_q[BIN_W-2:0], 1'b0};
                acc_q  <= acc_nxt;
            end
            if (last_step) begin
                bcd_out <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/bcd_seq_conv_chk.sv
module bcd_seq_conv_chk
    import bcdc_pkg::*;
#(
    parameter int BIN_W  = 8,
    parameter int DIGITS = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      busy,
    input logic                      done,
    input logic [DIGITS*DIGIT_W-1:0] bcd_out
);
    localparam int RL_W = $clog2(BIN_W + 1) + 1;

    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && bcd_out == '0));

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RL_W'(BIN_W)));

    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == RL_W'(BIN_W)));

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(bcd_out));

    for (genvar g = 0; g < DIGITS; g++) begin : g_rng
        p_digit_range_r9: assert property (@(posedge clk) disable iff (rst)
            bcd_out[g*DIGIT_W +: DIGIT_W] <= 4'd9);
    end

endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(
    .BIN_W  (BIN_W),
    .DIGITS (DIGITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .bcd_out (bcd_out)
);

// File: tb/bcd_seq_conv_bench.sv
`timescale 1ns/1ps
module bcd_seq_conv_bench;
    localparam int BIN_W  = 8;
    localparam int DIGITS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  bin_in = '0;
    logic        busy;
    logic        done;
    logic [11:0] bcd_out;

    int total = 0;
    int bad   = 0;
    logic [11:0] prev_res = '0;

    bcd_seq_conv #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_bcd_seq_conv (
        .clk(clk), .rst(rst), .start(start), .bin_in(bin_in),
        .busy(busy), .done(done), .bcd_out(bcd_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] expect_bcd(input int v);
        int h, t, u;
        h = v / 100;
        t = (v / 10) % 10;
        u = v % 10;
        return {h[3:0], t[3:0], u[3:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Runs one conversion; optionally raises start mid-run with another operand
    task automatic convert(input int v, input string tag, input bit poke, input int pv);
        int n;
        logic [11:0] exp;
        exp = expect_bcd(v);
        @(negedge clk);
        start  = 1'b1;
        bin_in = v[7:0];
        @(negedge clk);
        start  = 1'b0;
        bin_in = pv[7:0];
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(bcd_out == prev_res, "R8 old result kept while busy", int'(bcd_out), int'(prev_res));
        n = 0;
        while (busy && n < 40) begin
            n++;
            start = poke && (n == 3);
            @(negedge clk);
        end
        start = 1'b0;
        check(n == BIN_W, poke ? "R7 busy length with ignored start" : "R3 busy length", n, BIN_W);
        check(done == 1'b1, "R4 done after busy", int'(done), 1);
        check(bcd_out == exp, tag, int'(bcd_out), int'(exp));
        for (int d = 0; d < DIGITS; d++) begin
            if (bcd_out[d*4 +: 4] > 4'd9)
                check(1'b0, "R9 digit range", int'(bcd_out[d*4 +: 4]), 9);
        end
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", int'(done), 0);
        check(bcd_out == exp, "R8 result held after done", int'(bcd_out), int'(exp));
        prev_res = exp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R1: reset dominates a start request
        start  = 1'b1;
        bin_in = 8'hFF;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(bcd_out == 12'h000, "R1 result in reset", int'(bcd_out), 0);
        start = 1'b0;
        rst   = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        convert(8'h63, "R6 0x63", 1'b0, 0);
        convert(8'hFE, "R6 0xFE", 1'b0, 0);
        convert(8'hBB, "R6 0xBB", 1'b0, 0);
        convert(8'h2A, "R7 operand unchanged by ignored start", 1'b1, 8'hFF);
        convert(8'h00, "R7 zero operand with ignored start", 1'b1, 8'h99);

        // R8: idle gap keeps the result
        repeat (5) @(negedge clk);
        check(bcd_out == prev_res, "R8 result held while idle", int'(bcd_out), int'(prev_res));

        for (int v = 0; v < 256; v++) begin
            convert(v, "R5 sweep result", 1'b0, 0);
        end
        convert(255, "R5 maximum input", 1'b0, 0);

        summary();
    end

endmodule